// File: doc/BRIEF.md
# CEC Receiver Acknowledge Error Monitor

This block sits beside the receive path of a single-wire CEC controller. While the local receiver pulls the bus low to acknowledge a byte, the monitor takes two strobes: one at the falling edge that starts the acknowledge bit and one when the receiver releases the line. It then times two checks from these two reference points.

The first check is one sample of the bus, taken a short delay after the release. If the line is still low at that sample, another device is holding it and the monitor flags an acknowledge collision. If the line is high, the monitor watches it until the minimum bit period has run out, counted from the start of the bit. Any low seen in that window is a minimum-cycle error. The monitor answers that error by pulling the bus low itself for a fixed recovery pulse.

The block also flags a receive overrun when a byte completes before the previous one was read. It reports a waveform error from an external shape checker when that check is enabled. Each error sets its own sticky status bit. Software clears a bit by writing one to it, and an interrupt combines the enabled bits. All timing is counted in ticks of an external 0.1 ms strobe.

Top module: `cec_err_monitor`

## Requirements
- R1: After reset the pull-down is released, all four status bits are zero and the interrupt is low.
- R2: The bus input passes through a two-flop synchronizer. On the 3rd tick after the release strobe the synchronized line is sampled once. A low sample sets status bit 0 (collision) on the following clock.
- R3: After a collision the check for that bit ends. A low line afterwards sets neither status bit 1 nor the pull-down.
- R4: If the release sample is high, a low synchronized line seen before the 20th tick counted from the start strobe sets status bit 1 (minimum cycle).
- R5: The watch window closes on the 20th tick after the start strobe. A low line after that sets nothing.
- R6: A minimum-cycle error asserts the pull-down output for exactly 36 ticks, counted from the cycle the error is detected. The pull-down is released after that.
- R7: A byte-complete strobe while a byte is still unread sets status bit 2 (overrun). A read strobe in the same cycle as the completion prevents the overrun.
- R8: A pulse on the waveform-error input sets status bit 3 only while the waveform-check enable is high.
- R9: Status bits are sticky. A one on bit i of the clear input clears bit i only. A set in the same cycle wins over the clear.
- R10: The interrupt is high exactly when some status bit is set and its matching interrupt-enable bit is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe every 0.1 ms |
| line_in | input | 1 | Raw CEC bus level (1 = released) |
| ack_start | input | 1 | Strobe at the falling edge that begins the acknowledge bit |
| ack_end | input | 1 | Strobe when the receiver stops driving the acknowledge low |
| byte_done | input | 1 | Strobe when a received byte is complete |
| buf_read | input | 1 | Strobe when the receive buffer is read |
| wav_err_in | input | 1 | Error pulse from the external waveform checker |
| wav_en | input | 1 | Enables waveform-error reporting |
| irq_en | input | 4 | Interrupt enable per status bit |
| clr | input | 4 | Write-one-to-clear strobes per status bit |
| pull_low | output | 1 | Bus pull-down enable for the recovery pulse |
| status | output | 4 | Sticky status: [0] collision, [1] min cycle, [2] overrun, [3] waveform |
| irq | output | 1 | Interrupt request |

## Verification
A raw line change reaches the state logic two clocks later through the synchronizer, and the resulting status or pull-down change appears one clock after that. The bench therefore lets at least three clocks pass between a line change and the next tick or check. Tick-timed results take effect on the clock after the deciding tick, so each tick task waits three idle cycles before a check. This lets the bench probe the 2nd against the 3rd tick for the collision sample, the 19th against the 20th tick for the window end, and the 35th against the 36th tick for the recovery pulse. Overrun, waveform and clear effects are due one clock after their strobe, and they are sampled on the following falling edge.

// File: rtl/cec_err_monitor.sv
module cec_err_monitor #(
  parameter int DLY_TICKS   = 3,
  parameter int WIN_TICKS   = 20,
  parameter int PULSE_TICKS = 36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_in,
  input  logic       ack_start,
  input  logic       ack_end,
  input  logic       byte_done,
  input  logic       buf_read,
  input  logic       wav_err_in,
  input  logic       wav_en,
  input  logic [3:0] irq_en,
  input  logic [3:0] clr,
  output logic       pull_low,
  output logic [3:0] status,
  output logic       irq
);
  localparam int SW = $clog2(WIN_TICKS + 1);
  localparam int DMAX = (DLY_TICKS > PULSE_TICKS) ? DLY_TICKS : PULSE_TICKS;
  localparam int DW = $clog2(DMAX + 1);

  typedef enum logic [2:0] {IDLE, DRIVE, DELAY, WATCH, PULSE} st_t;
  st_t st;

  logic [1:0]    sync;
  logic          line_s;
  logic [SW-1:0] cnt_s;
  logic [DW-1:0] cnt_d;
  logic          col_hit, mc_hit, ovr_hit, wav_hit, full;
  logic [3:0]    set_v;

  assign line_s   = sync[1];
  assign pull_low = (st == PULSE);
  assign col_hit  = (st == DELAY) && tick && (cnt_d == DW'(DLY_TICKS - 1)) && !line_s;
  assign mc_hit   = (st == WATCH) && !line_s;
  assign ovr_hit  = byte_done && full && !buf_read;
  assign wav_hit  = wav_err_in && wav_en;
  assign set_v    = {wav_hit, ovr_hit, mc_hit, col_hit};
  assign irq      = |(status & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt_s <= '0;
      cnt_d <= '0;
    end else begin
      case (st)
        IDLE: if (ack_start) begin
          st    <= DRIVE;
          cnt_s <= '0;
        end
        DRIVE: begin
          if (tick) cnt_s <= cnt_s + 1'b1;
          if (ack_end) begin
            st    <= DELAY;
            cnt_d <= '0;
          end
        end
        DELAY: if (tick) begin
          cnt_s <= cnt_s + 1'b1;
          if (cnt_d == DW'(DLY_TICKS - 1)) st <= line_s ? WATCH : IDLE;
          else cnt_d <= cnt_d + 1'b1;
        end
        WATCH: begin
          if (!line_s) begin
            st    <= PULSE;
            cnt_d <= '0;
          end else if (tick) begin
            if (cnt_s >= SW'(WIN_TICKS - 1)) st <= IDLE;
            else cnt_s <= cnt_s + 1'b1;
          end
        end
        PULSE: if (tick) begin
          if (cnt_d == DW'(PULSE_TICKS - 1)) st <= IDLE;
          else cnt_d <= cnt_d + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      status <= '0;
    end else begin
      if (byte_done)     full <= 1'b1;
      else if (buf_read) full <= 1'b0;
      status <= (status & ~clr) | set_v;
    end
  end
endmodule

module cec_err_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_done,
  input logic       wav_err_in,
  input logic       wav_en,
  input logic [3:0] clr,
  input logic       pull_low,
  input logic [3:0] status
);
  a_r8_wav_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(wav_en && wav_err_in));
  a_r7_ovr_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(byte_done));
  a_r6_pulse_after_mc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_low) |-> status[1]);
  a_r3_no_pulse_on_col: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> !pull_low);
  a_r9_clear_col: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> $past(clr[0]));
  a_r9_clear_mc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> $past(clr[1]));
  a_r9_clear_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[2]) |-> $past(clr[2]));
  a_r9_clear_wav: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[3]) |-> $past(clr[3]));
endmodule

bind cec_err_monitor cec_err_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .wav_err_in(wav_err_in),
  .wav_en(wav_en), .clr(clr), .pull_low(pull_low), .status(status)
);

// File: tb/cec_err_monitor_test.sv
module cec_err_monitor_test;
  logic clk = 0, rst_n = 0, tick = 0, bus_rel = 1;
  logic ack_start = 0, ack_end = 0, byte_done = 0, buf_read = 0;
  logic wav_err_in = 0, wav_en = 0;
  logic [3:0] irq_en = 4'h0, clr = 4'h0, status;
  logic pull_low, irq, line_in;
  int tests = 0, fails = 0;

  assign line_in = bus_rel & ~pull_low;
  always #10 clk = ~clk;

  cec_err_monitor uut (.clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
    .ack_start(ack_start), .ack_end(ack_end), .byte_done(byte_done), .buf_read(buf_read),
    .wav_err_in(wav_err_in), .wav_en(wav_en), .irq_en(irq_en), .clr(clr),
    .pull_low(pull_low), .status(status), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      idle(3);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) ack_start = 1;
    @(negedge clk) ack_start = 0;
  endtask

  task automatic pulse_end();
    @(negedge clk) ack_end = 1;
    @(negedge clk) ack_end = 0;
  endtask

  task automatic set_line(logic v);
    @(negedge clk) bus_rel = v;
    idle(4);
  endtask

  task automatic clear_all();
    set_line(1);
    ticks(40);
    @(negedge clk) clr = 4'hF;
    @(negedge clk) clr = 4'h0;
  endtask

  task automatic t_reset();
    check("R1 status", status, 0);
    check("R1 pull_low", pull_low, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_clean();
    pulse_start(); set_line(0); ticks(5); set_line(1); pulse_end(); ticks(25);
    check("R2 clean ack no error", status, 0);
    check("R6 clean ack no pull", pull_low, 0);
  endtask

  task automatic t_collision();
    pulse_start(); set_line(0); ticks(5); pulse_end(); ticks(2);
    check("R2 no sample before 3rd tick", status, 0);
    ticks(1);
    check("R2 collision on 3rd tick", status, 4'b0001);
    ticks(10);
    check("R3 no min cycle after collision", status, 4'b0001);
    check("R3 no pull after collision", pull_low, 0);
    clear_all();
  endtask

  task automatic t_mincyc();
    pulse_start(); set_line(0); ticks(5); set_line(1); pulse_end(); ticks(5);
    check("R4 high sample no error", status, 0);
    set_line(0); set_line(1);
    check("R4 min cycle set", status, 4'b0010);
    check("R6 pull asserted", pull_low, 1);
    check("R6 bus held low", line_in, 0);
    ticks(35);
    check("R6 pull held at 35 ticks", pull_low, 1);
    ticks(1);
    check("R6 pull released at 36 ticks", pull_low, 0);
    clear_all();
  endtask

  task automatic t_window(int total);
    pulse_start(); set_line(0); ticks(5); set_line(1); pulse_end(); ticks(total - 5);
    set_line(0);
    if (total >= 20) begin
      check("R5 low after window ignored", status, 0);
      check("R5 no pull after window", pull_low, 0);
    end else begin
      check("R4 low at 19 ticks flagged", status, 4'b0010);
    end
    clear_all();
  endtask

  task automatic t_overrun();
    @(negedge clk) byte_done = 1;
    @(negedge clk) byte_done = 0;
    check("R7 first byte no overrun", status, 0);
    @(negedge clk) begin byte_done = 1; buf_read = 1; end
    @(negedge clk) begin byte_done = 0; buf_read = 0; end
    check("R7 read with completion no overrun", status, 0);
    @(negedge clk) byte_done = 1;
    @(negedge clk) byte_done = 0;
    check("R7 overrun set", status, 4'b0100);
    @(negedge clk) clr = 4'h4;
    @(negedge clk) clr = 4'h0;
    @(negedge clk) buf_read = 1;
    @(negedge clk) buf_read = 0;
    @(negedge clk) byte_done = 1;
    @(negedge clk) byte_done = 0;
    check("R7 after read no overrun", status, 0);
  endtask

  task automatic t_wave();
    @(negedge clk) wav_err_in = 1;
    @(negedge clk) wav_err_in = 0;
    check("R8 disabled ignored", status, 0);
    wav_en = 1;
    @(negedge clk) wav_err_in = 1;
    @(negedge clk) wav_err_in = 0;
    check("R8 enabled set", status, 4'b1000);
    wav_en = 0;
  endtask

  task automatic t_clear_irq();
    @(negedge clk) begin byte_done = 1; end
    @(negedge clk) byte_done = 0;
    check("R10 masked irq low", irq, 0);
    irq_en = 4'b0100;
    @(negedge clk);
    check("R10 enabled irq high", irq, 1);
    irq_en = 4'b0001;
    @(negedge clk);
    check("R10 other enable irq low", irq, 0);
    @(negedge clk) clr = 4'b0100;
    @(negedge clk) clr = 4'b0000;
    check("R9 w1c clears one bit", status, 4'b1000);
    wav_en = 1;
    @(negedge clk) begin clr = 4'b1000; wav_err_in = 1; end
    @(negedge clk) begin clr = 4'b0000; wav_err_in = 0; end
    check("R9 set wins over clear", status, 4'b1000);
    wav_en = 0;
    @(negedge clk) clr = 4'hF;
    @(negedge clk) clr = 4'h0;
    check("R9 all cleared", status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    t_reset();
    t_clean();
    t_collision();
    t_mincyc();
    t_window(19);
    t_window(20);
    t_overrun();
    t_wave();
    t_clear_irq();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule